// File: doc/BRIEF.md
# Timer Tick Prescaler

This block turns the system clock enable strobe into count-enable ticks for three independent timers. The strobe comes from the clock-rate controller. When that controller slows the core down, for example by the 1024:1 divider of power-management mode, the strobe arrives less often. Every timer tick slows down by the same factor, because each tick is counted out of strobes and never out of raw input clocks.

Each timer has its own prescale counter and its own rate-select bit.

- With its select bit clear, a timer uses the legacy rate of one tick per 12 strobes. This is the reset state of every timer.
- With its select bit set, the timer ticks once per 4 strobes.
- A global fast bit raises every selected timer to one tick per strobe.

A write to a select bit, or to the fast bit, restarts the affected prescale counters. The first tick at the new rate therefore comes a full period after the write.

Top module: `tmr_tick_gen`

## Requirements
- R1: Reset (rst high at a clock edge) clears all select bits, the fast bit and all prescale counters, and it drives every tick output low.
- R2: A timer whose select bit is 0 ticks once per 12 strobes. Its first tick follows the 12th strobe counted after reset or after its last clear.
- R3: A timer whose select bit is 1 ticks once per 4 strobes while the fast bit is 0.
- R4: A timer whose select bit is 1 ticks on every strobe while the fast bit is 1.
- R5: The fast bit has no effect on a timer whose select bit is 0. That timer keeps the 12-strobe rate.
- R6: Prescale counters advance only on clock edges where sys_stb is high. With no strobe, no tick is issued. A tick is high for one clock, in the cycle that follows the edge of the wrapping strobe.
- R7: Asserting sel_we[i] loads bit i of sel_wdata and clears counter i, even if a strobe arrives at the same edge, in which case that strobe is not counted. The other timers' counters are left untouched.
- R8: Asserting fast_we loads fast_wdata and clears every prescale counter.
- R9: Bit i of every vector port (sel_we, sel_wdata, tick) belongs to timer i. The timers run independently, each at its own selected rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_stb | input | 1 | System clock enable strobe from the clock-rate controller |
| sel_we | input | NUM_TMR | Per-timer write enable for the select bits |
| sel_wdata | input | NUM_TMR | Select bit values (0: 12-strobe rate, 1: fast rate) |
| fast_we | input | 1 | Write enable for the global fast bit |
| fast_wdata | input | 1 | Fast bit value (1: selected timers tick every strobe) |
| tick | output | NUM_TMR | Registered one-clock count-enable pulse per timer |

## Verification
The bench builds the block with its default parameters: three timers, a legacy divide of 12 and a mid divide of 4. With these values every rate is reached by strobe runs of a few dozen cycles. This means a single timer's full legacy period can be walked strobe by strobe, and the 4:1 and 1:1 rates can be compared against it in the same run. Strobe gaps of one to three clocks show that the tick counts follow strobes rather than clocks. Writes that are placed mid-period, or that fall on the same edge as a strobe, show which counters restart and which keep their phase.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

  typedef enum logic [1:0] {
    RATE_LEGACY  = 2'd0,
    RATE_QUARTER = 2'd1,
    RATE_FULL    = 2'd2
  } tick_rate_e;

  function automatic tick_rate_e pick_rate(input logic sel_bit, input logic fast_bit);
    if (!sel_bit)
      return RATE_LEGACY;
    else if (fast_bit)
      return RATE_FULL;
    else
      return RATE_QUARTER;
  endfunction

endpackage

// File: rtl/tmr_rate_reg.sv
module tmr_rate_reg #(
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TMR-1:0] sel_we,
  input  logic [NUM_TMR-1:0] sel_wdata,
  input  logic               fast_we,
  input  logic               fast_wdata,
  output logic [NUM_TMR-1:0] sel_q,
  output logic               fast_q,
  output logic [NUM_TMR-1:0] restart
);

  // A written select bit restarts its own counter; the fast bit restarts all.
  assign restart = sel_we | {NUM_TMR{fast_we}};

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)
        sel_q[i] <= 1'b0;
      else if (sel_we[i])
        sel_q[i] <= sel_wdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fast_q <= 1'b0;
    else if (fast_we)
      fast_q <= fast_wdata;
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_tick_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int MID_DIV  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb,
  input  logic       restart,
  input  tick_rate_e rate,
  output logic       tick
);

  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] MID_LAST  = CW'(MID_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          wrap;

  always_comb begin
    unique case (rate)
      RATE_QUARTER: last = MID_LAST;
      RATE_FULL:    last = '0;
      default:      last = SLOW_LAST;
    endcase
  end

  assign wrap = stb && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap)
        cnt <= '0;
      else if (stb)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_tick_pkg::*;
#(
  parameter int NUM_TMR  = 3,
  parameter int SLOW_DIV = 12,
  parameter int MID_DIV  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sys_stb,
  input  logic [NUM_TMR-1:0] sel_we,
  input  logic [NUM_TMR-1:0] sel_wdata,
  input  logic               fast_we,
  input  logic               fast_wdata,
  output logic [NUM_TMR-1:0] tick
);

  logic [NUM_TMR-1:0] sel_q;
  logic               fast_q;
  logic [NUM_TMR-1:0] restart;

  tmr_rate_reg #(.NUM_TMR(NUM_TMR)) u_rate_reg (
    .clk        (clk),
    .rst        (rst),
    .sel_we     (sel_we),
    .sel_wdata  (sel_wdata),
    .fast_we    (fast_we),
    .fast_wdata (fast_wdata),
    .sel_q      (sel_q),
    .fast_q     (fast_q),
    .restart    (restart)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    tmr_prescaler #(
      .SLOW_DIV (SLOW_DIV),
      .MID_DIV  (MID_DIV)
    ) u_presc (
      .clk     (clk),
      .rst     (rst),
      .stb     (sys_stb),
      .restart (restart[i]),
      .rate    (pick_rate(sel_q[i], fast_q)),
      .tick    (tick[i])
    );
  end

endmodule

// File: rtl/tmr_tick_gen_chk.sv
module tmr_tick_gen_chk #(
  parameter int NUM_TMR = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               sys_stb,
  input logic [NUM_TMR-1:0] sel_we,
  input logic               fast_we,
  input logic [NUM_TMR-1:0] sel_q,
  input logic               fast_q,
  input logic [NUM_TMR-1:0] tick
);

  // R1: a reset edge leaves every tick low
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (tick == '0));

  // R6: no strobe at an edge means no tick after it
  a_r6_tick_needs_stb: assert property (@(posedge clk) disable iff (rst)
    !sys_stb |=> (tick == '0));

  // R8: a fast-bit write silences all ticks for the next cycle
  a_r8_fast_restart: assert property (@(posedge clk) disable iff (rst)
    fast_we |=> (tick == '0));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R7: a select write suppresses that timer's tick
    a_r7_sel_restart: assert property (@(posedge clk) disable iff (rst)
      sel_we[i] |=> !tick[i]);

    // R6: ticks are one clock wide unless the timer runs at full rate
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (tick[i] && !(sel_q[i] && fast_q) && !sel_we[i] && !fast_we) |=> !tick[i]);
  end

endmodule

bind tmr_tick_gen tmr_tick_gen_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sys_stb (sys_stb),
  .sel_we  (sel_we),
  .fast_we (fast_we),
  .sel_q   (sel_q),
  .fast_q  (fast_q),
  .tick    (tick)
);

// File: tb/tmr_tick_gen_bench.sv
module tmr_tick_gen_bench;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sys_stb = 1'b0;
  logic [N-1:0] sel_we = '0;
  logic [N-1:0] sel_wdata = '0;
  logic         fast_we = 1'b0;
  logic         fast_wdata = 1'b0;
  logic [N-1:0] tick;

  int n_chk = 0;
  int n_fail = 0;
  int tc [N];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_tick_gen u_tmr_tick_gen (
    .clk        (clk),
    .rst        (rst),
    .sys_stb    (sys_stb),
    .sel_we     (sel_we),
    .sel_wdata  (sel_wdata),
    .fast_we    (fast_we),
    .fast_wdata (fast_wdata),
    .tick       (tick)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic       fast;
    logic [3:0] gap;
    logic [7:0] nstb;
    logic [7:0] e0;
    logic [7:0] e1;
    logic [7:0] e2;
  } vec_t;

  localparam int NV = 6;
  // Expected tick counts after a full write: legacy 12, quarter 4, full 1
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 4'd1, 8'd24, 8'd2,  8'd2,  8'd2 },  // R2 all legacy
    '{3'b001, 1'b0, 4'd1, 8'd24, 8'd6,  8'd2,  8'd2 },  // R3 R9 timer0 quarter
    '{3'b010, 1'b1, 4'd1, 8'd12, 8'd1,  8'd12, 8'd1 },  // R4 R5 timer1 full
    '{3'b111, 1'b0, 4'd3, 8'd20, 8'd5,  8'd5,  8'd5 },  // R3 R6 gapped strobes
    '{3'b101, 1'b1, 4'd2, 8'd10, 8'd10, 8'd0,  8'd10},  // R4 R9 mixed
    '{3'b000, 1'b0, 4'd1, 8'd11, 8'd0,  8'd0,  8'd0 }   // R2 just short
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clr_counts();
    for (int i = 0; i < N; i++) tc[i] = 0;
  endtask

  // One negedge: count the tick from the last posedge, then drive the strobe
  task automatic step(input logic s);
    @(negedge clk);
    for (int i = 0; i < N; i++) if (tick[i]) tc[i]++;
    sys_stb = s;
    sel_we  = '0;
    fast_we = 1'b0;
  endtask

  task automatic wr(input logic [N-1:0] we, input logic [N-1:0] d,
                    input logic fwe, input logic fd, input logic s);
    @(negedge clk);
    for (int i = 0; i < N; i++) if (tick[i]) tc[i]++;
    sel_we = we; sel_wdata = d; fast_we = fwe; fast_wdata = fd; sys_stb = s;
    step(1'b0);
  endtask

  task automatic run(input int gap, input int nstb);
    for (int k = 0; k < nstb; k++) begin
      for (int g = 1; g < gap; g++) step(1'b0);
      step(1'b1);
    end
    step(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sys_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 tick low in reset", int'(tick), 0);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();

    // R1 R2: default legacy rate straight out of reset
    clr_counts(); run(1, 11);
    for (int i = 0; i < N; i++) chk("R1 R2 no tick before 12th strobe", tc[i], 0);
    clr_counts(); run(1, 1);
    for (int i = 0; i < N; i++) chk("R2 tick on 12th strobe", tc[i], 1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      wr('1, VECS[v].sel, 1'b1, VECS[v].fast, 1'b0);
      clr_counts(); run(int'(VECS[v].gap), int'(VECS[v].nstb));
      chk($sformatf("vec%0d timer0", v), tc[0], int'(VECS[v].e0));
      chk($sformatf("vec%0d timer1", v), tc[1], int'(VECS[v].e1));
      chk($sformatf("vec%0d timer2", v), tc[2], int'(VECS[v].e2));
    end

    // R6: no strobes, no ticks, even at full rate
    wr('1, 3'b111, 1'b1, 1'b1, 1'b0);
    clr_counts(); repeat (40) step(1'b0);
    for (int i = 0; i < N; i++) chk("R6 idle without strobe", tc[i], 0);

    // R1: mid-run reset clears selects, fast bit and counters
    wr('1, 3'b111, 1'b1, 1'b0, 1'b0);
    run(1, 2);
    do_reset();
    clr_counts(); run(1, 11);
    for (int i = 0; i < N; i++) chk("R1 counters and selects cleared", tc[i], 0);

    // R7: select write clears only its own counter, beats a same-edge strobe
    do_reset();
    wr(3'b001, 3'b001, 1'b0, 1'b0, 1'b0);
    clr_counts(); run(1, 3);
    wr(3'b001, 3'b001, 1'b0, 1'b0, 1'b1);
    clr_counts(); run(1, 3);
    chk("R7 timer0 restarted by write", tc[0], 0);
    clr_counts(); run(1, 1);
    chk("R7 timer0 ticks a full period after write", tc[0], 1);
    clr_counts(); run(1, 5);
    chk("R7 timer1 phase kept", tc[1], 1);
    chk("R7 timer2 phase kept", tc[2], 1);

    // R8: fast-bit write restarts every counter
    wr('1, 3'b111, 1'b1, 1'b0, 1'b0);
    run(1, 2);
    wr('0, '0, 1'b1, 1'b0, 1'b0);
    clr_counts(); run(1, 3);
    for (int i = 0; i < N; i++) chk("R8 counters restarted", tc[i], 0);
    clr_counts(); run(1, 1);
    for (int i = 0; i < N; i++) chk("R8 tick after full period", tc[i], 1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule